// File: doc/BRIEF.md
# Privilege-Filtered Address Match Unit

This block compares the current instruction fetch address and the current data access address against a bank of hardware triggers. Each trigger supplies a control word and a compare value. A trigger that is enabled, has the right access kind selected, permits the current privilege level and holds a compare value equal to the presented address raises a breakpoint request. The core then takes a breakpoint exception before the instruction or access takes effect.

Two control-word layouts take part: an older layout (type code 2) and a newer one (type code 6). Every other type code is inert. Only the newer layout can fire while virtualization is on, and in that state it checks its own pair of virtual-mode enable bits. The request is purely combinational from the inputs. The index of the lowest matching trigger is registered on the following clock edge so that debug software can read it.

Top module: `trig_match_unit`

## Requirements
- R1: A trigger takes part only if at least one privilege-mode bit is set and at least one access bit is set. The privilege-mode bits are U bit 3, S bit 4 and M bit 6, plus VU bit 23 and VS bit 24 for type 6. The access bits are load bit 0, store bit 1 and execute bit 2.
- R2: An execute match requires execute bit 2, a valid fetch, and a fetch address exactly equal to the trigger's compare value.
- R3: A data match requires a valid access, load bit 0 for a read or store bit 1 for a write (`dacc_wr`=1 is a write), and an access address exactly equal to the compare value. The execute bit alone never produces a data match.
- R4: With virtualization off, the control word bit at position 3+`priv` must be 1 (`priv` 0=U, 1=S, 3=M).
- R5: A trigger whose type field (bits XLEN-1..XLEN-4) is 2 never fires while `virt_en` is 1.
- R6: With `virt_en`=1, a type 6 trigger checks bit 23+`priv` (VU at 23, VS at 24) instead of the normal-mode bits. With `virt_en`=0 it checks bit 3+`priv` like type 2.
- R7: Triggers whose type field is neither 2 nor 6 never produce a hit.
- R8: When several triggers hit in one cycle, a single request is raised. `bp_idx` takes the lowest hitting index at the next rising clock edge and holds its value in cycles without a request.
- R9: Fetch and data checks are independent, and either one asserts `bp_req` in the same cycle as its inputs, with no register on the path.
- R10: During and after reset, before any hit, `bp_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_bus | input | NTRIG*XLEN | Control words, trigger i at bits i*XLEN and up |
| cmp_bus | input | NTRIG*XLEN | Compare values, same packing |
| fetch_vld | input | 1 | Fetch address valid |
| fetch_addr | input | XLEN | Instruction fetch address |
| dacc_vld | input | 1 | Data access valid |
| dacc_wr | input | 1 | 1 = store, 0 = load |
| dacc_addr | input | XLEN | Data access address |
| priv | input | 2 | Current privilege level |
| virt_en | input | 1 | Virtualization enabled |
| bp_req | output | 1 | Breakpoint request, combinational |
| bp_idx | output | IDXW | Registered index of the lowest hitting trigger |

## Verification
The bench builds the unit with its defaults of four triggers and a 32-bit address width. With four triggers, one cycle can contain a fetch hit on one trigger and a data hit on another, and the lowest-index selection can be seen among non-adjacent hits. With a 32-bit width, the type field sits in the top nibble and the virtual-mode bits at 23 and 24 fall inside the word. A table of single-trigger cases covers every mode, type and access combination, and directed cases cover multiple hits and the holding of the index.

// File: rtl/trig_match_unit.sv
module trig_match_unit #(
  parameter int NTRIG = 4,
  parameter int XLEN  = 32,
  localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTRIG*XLEN-1:0] ctl_bus,
  input  logic [NTRIG*XLEN-1:0] cmp_bus,
  input  logic                  fetch_vld,
  input  logic [XLEN-1:0]       fetch_addr,
  input  logic                  dacc_vld,
  input  logic                  dacc_wr,
  input  logic [XLEN-1:0]       dacc_addr,
  input  logic [1:0]            priv,
  input  logic                  virt_en,
  output logic                  bp_req,
  output logic [IDXW-1:0]       bp_idx
);

  localparam int NORM_BASE = 3;
  localparam int VIRT_BASE = 23;

  logic [NTRIG-1:0] hit_vec, is_old, is_new;
  logic [IDXW-1:0]  low_idx;

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    logic [XLEN-1:0] ctl, cmp, norm_sh, virt_sh;
    logic [3:0]      typ;
    logic            mode_on, acc_on, armed, priv_ok, f_hit, d_hit;

    assign ctl = ctl_bus[i*XLEN +: XLEN];
    assign cmp = cmp_bus[i*XLEN +: XLEN];
    assign typ = ctl[XLEN-1 -: 4];
    assign is_old[i] = (typ == 4'd2);
    assign is_new[i] = (typ == 4'd6);

    assign mode_on = ctl[3] | ctl[4] | ctl[6] | (is_new[i] & (ctl[23] | ctl[24]));
    assign acc_on  = |ctl[2:0];
    assign armed   = (is_old[i] | is_new[i]) & mode_on & acc_on;

    assign norm_sh = ctl >> (NORM_BASE + int'(priv));
    assign virt_sh = ctl >> (VIRT_BASE + int'(priv));
    assign priv_ok = virt_en ? (is_new[i] & virt_sh[0]) : norm_sh[0];

    assign f_hit = fetch_vld & ctl[2] & (fetch_addr == cmp);
    assign d_hit = dacc_vld & (dacc_wr ? ctl[1] : ctl[0]) & (dacc_addr == cmp);

    assign hit_vec[i] = armed & priv_ok & (f_hit | d_hit);
  end

  always_comb begin
    low_idx = '0;
    for (int k = NTRIG - 1; k >= 0; k--)
      if (hit_vec[k]) low_idx = IDXW'(k);
  end

  assign bp_req = |hit_vec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bp_idx <= '0;
    else if (bp_req) bp_idx <= low_idx;

  logic [NTRIG-1:0] below_idx;
  assign below_idx = (NTRIG'(1) << bp_idx) - NTRIG'(1);

  AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> (fetch_vld || dacc_vld)); // R9
  AST_OLD_TYPE_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    virt_en |-> ((hit_vec & is_old) == '0)); // R5
  AST_OTHER_TYPES: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec & ~(is_old | is_new)) == '0)); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_req |=> $stable(bp_idx)); // R8
  AST_IDX_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |=> ((($past(hit_vec)) >> bp_idx) & NTRIG'(1)) != '0); // R8
  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |=> (($past(hit_vec)) & below_idx) == '0); // R8

endmodule

// File: tb/test_trig_match_unit.sv
module test_trig_match_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int XL = 32;

  localparam logic [31:0] T2 = 32'h2000_0000, T6 = 32'h6000_0000;
  localparam logic [31:0] BL = 32'h1, BS = 32'h2, BX = 32'h4;
  localparam logic [31:0] MU = 32'h8, MS = 32'h10, MM = 32'h40;
  localparam logic [31:0] VU = 32'h0080_0000, VS = 32'h0100_0000;
  localparam logic [31:0] A1 = 32'h1000_0010;

  typedef struct packed {
    logic [31:0] ctl;
    logic        fv;
    logic [31:0] fa;
    logic        dv;
    logic        dw;
    logic [31:0] da;
    logic [1:0]  pv;
    logic        vz;
    logic        ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{T2|MM|BX, 1, A1,      0, 0, 0,       2'd3, 0, 1, 4'd2},  // R2
    '{T2|MM|BX, 1, A1+4,    0, 0, 0,       2'd3, 0, 0, 4'd2},  // R2
    '{T2|MM|BX, 1, A1,      0, 0, 0,       2'd0, 0, 0, 4'd4},  // R4
    '{T2|MU|BX, 1, A1,      0, 0, 0,       2'd0, 0, 1, 4'd4},  // R4
    '{T2|MS|BX, 1, A1,      0, 0, 0,       2'd1, 0, 1, 4'd4},  // R4
    '{T2|MM,    1, A1,      1, 0, A1,      2'd3, 0, 0, 4'd1},  // R1
    '{T2|BX|BL, 1, A1,      1, 0, A1,      2'd3, 0, 0, 4'd1},  // R1
    '{T2|MM|BL, 0, 0,       1, 0, A1,      2'd3, 0, 1, 4'd3},  // R3
    '{T2|MM|BL, 0, 0,       1, 1, A1,      2'd3, 0, 0, 4'd3},  // R3
    '{T2|MM|BS, 0, 0,       1, 1, A1,      2'd3, 0, 1, 4'd3},  // R3
    '{T2|MM|BS, 0, 0,       1, 1, A1+8,    2'd3, 0, 0, 4'd3},  // R3
    '{T2|MM|BX, 0, 0,       1, 0, A1,      2'd3, 0, 0, 4'd3},  // R3
    '{T2|MU|BX, 1, A1,      0, 0, 0,       2'd0, 1, 0, 4'd5},  // R5
    '{T6|VU|BX, 1, A1,      0, 0, 0,       2'd0, 1, 1, 4'd6},  // R6
    '{T6|MU|BX, 1, A1,      0, 0, 0,       2'd0, 1, 0, 4'd6},  // R6
    '{T6|VS|BL, 0, 0,       1, 0, A1,      2'd1, 1, 1, 4'd6},  // R6
    '{T6|VU|BX, 1, A1,      0, 0, 0,       2'd0, 0, 0, 4'd6},  // R6
    '{T6|MU|BX, 1, A1,      0, 0, 0,       2'd0, 0, 1, 4'd6},  // R6
    '{32'h5000_0000|MM|BX, 1, A1, 0, 0, 0, 2'd3, 0, 0, 4'd7},  // R7
    '{MM|BX,    1, A1,      0, 0, 0,       2'd3, 0, 0, 4'd7},  // R7
    '{T2|MM|BX, 0, A1,      0, 0, 0,       2'd3, 0, 0, 4'd9}   // R9
  };

  logic clk = 0, rst_n = 0;
  logic [NT*XL-1:0] ctl_bus, cmp_bus;
  logic fetch_vld, dacc_vld, dacc_wr, virt_en;
  logic [XL-1:0] fetch_addr, dacc_addr;
  logic [1:0] priv;
  logic bp_req;
  logic [1:0] bp_idx;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_match_unit #(.NTRIG(NT), .XLEN(XL)) i_trig_match_unit (
    .clk(clk), .rst_n(rst_n), .ctl_bus(ctl_bus), .cmp_bus(cmp_bus),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .dacc_vld(dacc_vld),
    .dacc_wr(dacc_wr), .dacc_addr(dacc_addr), .priv(priv), .virt_en(virt_en),
    .bp_req(bp_req), .bp_idx(bp_idx));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_vld = 0; dacc_vld = 0; dacc_wr = 0;
    fetch_addr = 0; dacc_addr = 0; priv = 2'd3; virt_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ctl_bus = '0;
    for (int i = 0; i < NT; i++) cmp_bus[i*XL +: XL] = 32'h1000_0000 + 32'(i*16);
    idle();
    #(CLK_PERIOD*2 + 1);
    check(bp_idx == 0, "R10 idx in reset", int'(bp_idx), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(bp_idx == 0, "R10 idx after reset", int'(bp_idx), 0);
    check(bp_req == 0, "R10 req idle", int'(bp_req), 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ctl_bus = '0;
      ctl_bus[1*XL +: XL] = VEC[v].ctl;
      fetch_vld = VEC[v].fv; fetch_addr = VEC[v].fa;
      dacc_vld = VEC[v].dv; dacc_wr = VEC[v].dw; dacc_addr = VEC[v].da;
      priv = VEC[v].pv; virt_en = VEC[v].vz;
      #1;
      if (bp_req !== VEC[v].ex) $display("vector %0d (req R%0d)", v, VEC[v].rq);
      check(bp_req === VEC[v].ex, $sformatf("R%0d vector %0d", VEC[v].rq, v),
            int'(bp_req), int'(VEC[v].ex));
      @(posedge clk); #1;
      if (VEC[v].ex)
        check(bp_idx == 2'd1, $sformatf("R8 idx vector %0d", v), int'(bp_idx), 1);
    end

    // R8 + R9: fetch hit on trigger 3 and data hit on trigger 2 in one cycle
    @(negedge clk);
    ctl_bus = '0;
    ctl_bus[3*XL +: XL] = T2|MM|BX;
    ctl_bus[2*XL +: XL] = T2|MM|BS;
    fetch_vld = 1; fetch_addr = 32'h1000_0030;
    dacc_vld = 1; dacc_wr = 1; dacc_addr = 32'h1000_0020;
    priv = 2'd3; virt_en = 0;
    #1 check(bp_req == 1, "R9 fetch+data same cycle", int'(bp_req), 1);
    @(posedge clk); #1 check(bp_idx == 2'd2, "R8 lowest of 2,3", int'(bp_idx), 2);

    // R9: data side only from trigger 3 region absent, fetch alone still fires
    @(negedge clk);
    dacc_vld = 0;
    #1 check(bp_req == 1, "R9 fetch alone", int'(bp_req), 1);
    @(posedge clk); #1 check(bp_idx == 2'd3, "R8 single hit idx 3", int'(bp_idx), 3);

    // R8: hits on triggers 0 and 3 -> 0 reported
    @(negedge clk);
    ctl_bus[0*XL +: XL] = T6|MM|BL;
    dacc_vld = 1; dacc_wr = 0; dacc_addr = 32'h1000_0000;
    @(posedge clk); #1 check(bp_idx == 2'd0, "R8 lowest of 0,3", int'(bp_idx), 0);

    // R8: index holds while nothing hits
    @(negedge clk);
    ctl_bus[2*XL +: XL] = T2|MM|BX;
    fetch_vld = 1; fetch_addr = 32'h1000_0020; dacc_vld = 0;
    @(posedge clk); #1 check(bp_idx == 2'd2, "R8 idx 2", int'(bp_idx), 2);
    @(negedge clk); idle(); priv = 2'd0;
    #1 check(bp_req == 0, "R8 no hit", int'(bp_req), 0);
    @(posedge clk); #1 check(bp_idx == 2'd2, "R8 idx holds", int'(bp_idx), 2);
    @(posedge clk); #1 check(bp_idx == 2'd2, "R8 idx still holds", int'(bp_idx), 2);

    // R1: mode bit without access bits stays silent on a matching address
    @(negedge clk);
    ctl_bus = '0; ctl_bus[0*XL +: XL] = T6|VU|VS|MM;
    fetch_vld = 1; fetch_addr = 32'h1000_0000; priv = 2'd3;
    #1 check(bp_req == 0, "R1 no access bits", int'(bp_req), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule